// File: doc/BRIEF.md
# Conditional Branch Evaluator

This block decides whether a relative branch is taken and computes where execution continues. Each request presents a 4-bit condition selector, the four arithmetic status flags (negative, zero, overflow, carry), the address of the branch opcode and an 8-bit signed displacement. The result is registered on a valid strobe and appears one clock later.

The selectors are arranged in pairs. The even code of each pair tests a predicate, and the odd code tests the inverse of that predicate. The predicates cover an always/never pair, unsigned magnitude comparisons, signed magnitude comparisons and single-flag tests. A branch instruction is two bytes long. The fall-through address is therefore the opcode address plus 2. A taken branch adds the sign-extended displacement to that address. Forward reach is 127 bytes and backward reach is 128 bytes. The sum wraps modulo 2^16.

The block only reads the flags and never drives them.

Top module: `branch_eval`

## Requirements
- R1: While reset is asserted and after it is released, with no request yet made, `res_valid` and `res_taken` are 0 and `res_next_pc` is 0x0000.
- R2: `res_valid` is 1 in the cycle after the cycle in which `eval_valid` is sampled high. It is 0 after a cycle in which `eval_valid` is sampled low.
- R3: In a cycle in which `eval_valid` is low, `res_taken` and `res_next_pc` keep their values, whatever the other inputs do.
- R4: Selector 0 is always taken and selector 1 is never taken, for every flag combination.
- R5: Selector 2 (unsigned higher) is taken when C=0 and Z=0. Selector 3 (lower-or-same) is taken when C=1 or Z=1.
- R6: Selector 4 (carry clear, higher-or-same) is taken when C=0. Selector 5 (carry set, lower) is taken when C=1.
- R7: Selector 6 (not equal) is taken when Z=0. Selector 7 (equal) is taken when Z=1.
- R8: Selectors 8 and 9 test V=0 and V=1. Selectors 10 and 11 test N=0 and N=1.
- R9: Selector 12 (signed greater-or-equal) is taken when N equals V. Selector 13 (signed less-than) is taken when N differs from V.
- R10: Selector 14 (signed greater-than) is taken when N equals V and Z=0. Selector 15 (signed less-or-equal) is taken when N differs from V or Z=1.
- R11: For every flag combination, selectors 2k and 2k+1 give opposite taken decisions.
- R12: When a branch is taken, `res_next_pc` = (op_addr + 2 + sign-extended disp) mod 2^16. Displacement 0x7F reaches +127 and 0x80 reaches -128.
- R13: When a branch is not taken, `res_next_pc` = (op_addr + 2) mod 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval_valid | input | 1 | Request strobe; inputs are captured when high |
| cond_sel | input | 4 | Branch condition selector |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| op_addr | input | 16 | Address of the branch opcode |
| disp | input | 8 | Signed displacement byte |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_taken | output | 1 | Branch taken decision |
| res_next_pc | output | 16 | Address of the next instruction |

## Verification
The hardest cases to reach are the address wraps. One is a taken forward branch whose target crosses 0xFFFF into low memory. The other is a backward branch from near address zero that wraps to the top of the space. Both need particular pairs of opcode address and displacement, combined with flags that make the branch taken.

The stimulus sweeps all 16 selectors against all 16 flag combinations. For every one of these combinations it tries opcode addresses at 0x0000, 0xFF7F and 0xFFFE, together with the displacements 0x00, 0x01, 0x7F, 0x80, 0x81 and 0xFF. Every wrap direction is therefore hit under both taken and not-taken decisions.

// File: rtl/branch_eval.sv
module branch_eval #(
  parameter int ADDR_W      = 16,
  parameter int DISP_W      = 8,
  parameter int INSTR_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_valid,
  input  logic [3:0]        cond_sel,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic              flag_v,
  input  logic              flag_c,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DISP_W-1:0] disp,
  output logic              res_valid,
  output logic              res_taken,
  output logic [ADDR_W-1:0] res_next_pc
);

  localparam int EXT_W = ADDR_W - DISP_W;

  logic [7:0]        pred;
  logic              take;
  logic [ADDR_W-1:0] fall_pc;
  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] jump_pc;

  assign pred[0] = 1'b1;
  assign pred[1] = ~flag_c & ~flag_z;
  assign pred[2] = ~flag_c;
  assign pred[3] = ~flag_z;
  assign pred[4] = ~flag_v;
  assign pred[5] = ~flag_n;
  assign pred[6] = ~(flag_n ^ flag_v);
  assign pred[7] = ~(flag_n ^ flag_v) & ~flag_z;

  assign take     = pred[cond_sel[3:1]] ^ cond_sel[0];
  assign fall_pc  = op_addr + ADDR_W'(INSTR_BYTES);
  assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign jump_pc  = fall_pc + disp_ext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_taken   <= 1'b0;
      res_next_pc <= '0;
    end else begin
      res_valid <= eval_valid;
      if (eval_valid) begin
        res_taken   <= take;
        res_next_pc <= take ? jump_pc : fall_pc;
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval_valid |=> res_valid);
  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_valid |=> !res_valid);
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_valid |=> ($stable(res_taken) && $stable(res_next_pc)));
  // R4
  always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_valid && cond_sel == 4'd0) |=> res_taken);
  // R4
  never_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_valid && cond_sel == 4'd1) |=> !res_taken);
  // R7
  equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_valid && cond_sel == 4'd7) |=> (res_taken == $past(flag_z)));
  // R13
  fallthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_valid && cond_sel == 4'd1) |=>
      (res_next_pc == ADDR_W'($past(op_addr) + ADDR_W'(INSTR_BYTES))));

endmodule

// File: tb/sim_branch_eval.sv
`timescale 1ns/1ps
module sim_branch_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        eval_valid = 1'b0;
  logic [3:0]  cond_sel = '0;
  logic        flag_n = 1'b0, flag_z = 1'b0, flag_v = 1'b0, flag_c = 1'b0;
  logic [15:0] op_addr = '0;
  logic [7:0]  disp = '0;
  logic        res_valid, res_taken;
  logic [15:0] res_next_pc;

  int checks = 0;
  int failures = 0;
  logic [15:0] taken_mask;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  branch_eval u0 (
    .clk(clk), .rst_n(rst_n), .eval_valid(eval_valid), .cond_sel(cond_sel),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
    .op_addr(op_addr), .disp(disp),
    .res_valid(res_valid), .res_taken(res_taken), .res_next_pc(res_next_pc)
  );

  function automatic bit exp_taken(input int sel, input bit n, input bit z, input bit v, input bit c);
    case (sel)
      0:  return 1'b1;                 // R4
      1:  return 1'b0;                 // R4
      2:  return (c == 0) && (z == 0); // R5
      3:  return (c == 1) || (z == 1); // R5
      4:  return c == 0;               // R6
      5:  return c == 1;               // R6
      6:  return z == 0;               // R7
      7:  return z == 1;               // R7
      8:  return v == 0;               // R8
      9:  return v == 1;               // R8
      10: return n == 0;               // R8
      11: return n == 1;               // R8
      12: return n == v;               // R9
      13: return n != v;               // R9
      14: return (n == v) && !z;       // R10
      default: return (n != v) || z;   // R10
    endcase
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] addrs [3];
    logic [7:0]  disps [6];
    addrs = '{16'h0000, 16'hFF7F, 16'hFFFE};
    disps = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'h81, 8'hFF};

    repeat (3) @(negedge clk);
    check("R1 valid in reset", res_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid", res_valid, 0);
    check("R1 taken", res_taken, 0);
    check("R1 next_pc", res_next_pc, 0);

    for (int f = 0; f < 16; f++) begin
      for (int s = 0; s < 16; s++) begin
        for (int a = 0; a < 3; a++) begin
          for (int d = 0; d < 6; d++) begin
            bit          et;
            logic [15:0] epc;
            cond_sel = 4'(s);
            {flag_n, flag_z, flag_v, flag_c} = 4'(f);
            op_addr = addrs[a];
            disp = disps[d];
            eval_valid = 1'b1;
            et = exp_taken(s, f[3], f[2], f[1], f[0]);
            if (et) epc = 16'(int'(op_addr) + 2 + int'($signed(disp)));   // R12
            else    epc = 16'(int'(op_addr) + 2);                         // R13
            @(negedge clk);
            eval_valid = 1'b0;
            check("R2 valid after request", res_valid, 1);
            check(et ? "R12 taken target" : "R13 fall-through", res_next_pc, epc);
            check("R4-R10 taken decision", res_taken, et);
            taken_mask[s] = res_taken;
            if (d == 5 && a == 2) begin
              cond_sel = ~cond_sel;
              op_addr = 16'h5A5A;
              disp = 8'h33;
              {flag_n, flag_z, flag_v, flag_c} = ~4'(f);
              @(negedge clk);
              check("R2 valid drops", res_valid, 0);
              check("R3 taken held", res_taken, et);
              check("R3 next_pc held", res_next_pc, epc);
            end
          end
        end
      end
      for (int k = 0; k < 8; k++)
        check("R11 pair complement", taken_mask[2*k] ^ taken_mask[2*k+1], 1);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule